// File: doc/BRIEF.md
# Firmware Hub Bus Target

This block is the target side of a nibble-serial firmware-hub bus. It listens on a 4-bit data bus and on an active-low frame line. It decodes each cycle's fields in this order: a start code, a device-select nibble, seven address nibbles and a size nibble. Every access it accepts becomes one request on a simple back-end port. Address bit 22 steers the request either to the flash core or to the register space.

Writes collect one data byte, low nibble first, and issue the request only once the byte is complete. Reads issue their request as soon as the size nibble is accepted. The target then answers with two turnaround nibbles, a zero sync nibble, the returned byte (low nibble first) and two final turnaround nibbles.

The target never reports an error. A bad start code, a device-select mismatch or a non-zero size nibble leaves the bus quiet. Pulling the frame line low in the middle of a cycle drops the drive at once and returns the decoder to idle.

Top module: `fwh_target`

## Requirements
- R1: Out of reset, and whenever no accepted cycle has reached a drive slot, `bus_oe` is 0.
- R2: A cycle starts only on a clock where `frame_n` is 0 and `bus_in` is 4'b1101 (read) or 4'b1110 (write). Any other start nibble produces no request and no drive.
- R3: The nibble after the start must equal `id_strap`. Otherwise the target raises no request and leaves `bus_oe` at 0 for the rest of the cycle.
- R4: The seven address nibbles arrive most significant first, forming a 28-bit address. `req_addr` carries only bits 19:0, and the upper bits (apart from bit 22) do not change the outcome.
- R5: `req_flash` equals address bit 22: 1 selects the flash core and 0 selects the register space.
- R6: A size nibble other than 4'b0000 returns the target to idle with no request and no drive.
- R7: For a read, `req_valid` pulses for one clock right after the size nibble. The target then drives the following, one nibble per clock: nothing for one turnaround clock, 4'b1111, sync 4'b0000, `rsp_rdata[3:0]`, `rsp_rdata[7:4]`, 4'b1111, and then releases the bus. `rsp_rdata` is sampled during the sync clock.
- R8: For a write, the two nibbles after the size nibble form the byte (low nibble first), and any value is accepted. A single `req_valid` pulse with `req_write`=1 follows the second nibble. The target then drives nothing for one clock, 4'b1111, 4'b0000, 4'b1111, and then releases the bus.
- R9: `frame_n` at 0 during an active cycle forces `bus_oe` to 0 in that same clock and returns the target to idle. A write aborted before its second data nibble issues no request. A request already issued stays issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low frame marker; low mid-cycle aborts |
| bus_in | input | 4 | Nibble received from the bus |
| bus_out | output | 4 | Nibble driven onto the bus |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| id_strap | input | 4 | Device-select value this target answers to |
| req_valid | output | 1 | One-clock back-end request strobe |
| req_write | output | 1 | 1 for write, 0 for read |
| req_flash | output | 1 | 1 targets flash core, 0 targets registers |
| req_addr | output | 20 | Decoded low address bits |
| req_wdata | output | 8 | Write byte |
| rsp_rdata | input | 8 | Read byte from the back end, held until the sync clock |

## Verification
The bench counts drive cycles nibble by nibble. A decoder with an off-by-one address count would show the sync nibble or the data a clock early or late, and swapped data nibbles would return the high half first. It sends a bad start code, a wrong device select and a non-zero size nibble, each followed by traffic that would look valid. A decoder that failed to reset would answer that traffic on the bus or raise a request. Aborts are placed mid-read, between the two write nibbles and just after a write request. A design with a registered abort would still drive for one clock, and a design that issued writes early would show a request for the half-written byte.

// File: rtl/fwh_target.sv
module fwh_target #(
  parameter int ADDR_NIBS = 7,
  parameter int DEC_BITS  = 20,
  parameter int SEL_BIT   = 22
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_n,
  input  logic [3:0]          bus_in,
  output logic [3:0]          bus_out,
  output logic                bus_oe,
  input  logic [3:0]          id_strap,
  output logic                req_valid,
  output logic                req_write,
  output logic                req_flash,
  output logic [DEC_BITS-1:0] req_addr,
  output logic [7:0]          req_wdata,
  input  logic [7:0]          rsp_rdata
);
  localparam int ADDR_W = 4 * ADDR_NIBS;
  localparam int CNT_W  = $clog2(ADDR_NIBS);
  localparam logic [3:0] CODE_RD = 4'b1101;
  localparam logic [3:0] CODE_WR = 4'b1110;

  typedef enum logic [3:0] {
    S_IDLE, S_IDSEL, S_ADDR, S_MSIZE, S_WD0, S_WD1, S_TAR0,
    S_TAR1, S_SYNC, S_RD0, S_RD1, S_TAR2, S_TAR3
  } st_t;

  st_t               st;
  logic              is_rd;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        data;
  logic              req_q;
  logic              drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      is_rd <= 1'b0;
      cnt   <= '0;
      addr  <= '0;
      data  <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (st != S_IDLE && !frame_n) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE:
            if (!frame_n && (bus_in == CODE_RD || bus_in == CODE_WR)) begin
              st    <= S_IDSEL;
              is_rd <= (bus_in == CODE_RD);
            end
          S_IDSEL: begin
            cnt <= '0;
            st  <= (bus_in == id_strap) ? S_ADDR : S_IDLE;
          end
          S_ADDR: begin
            addr <= {addr[ADDR_W-5:0], bus_in};
            cnt  <= cnt + 1'b1;
            if (cnt == CNT_W'(ADDR_NIBS - 1)) st <= S_MSIZE;
          end
          S_MSIZE:
            if (bus_in != 4'b0000) st <= S_IDLE;
            else if (is_rd) begin
              st    <= S_TAR0;
              req_q <= 1'b1;
            end else st <= S_WD0;
          S_WD0: begin
            data[3:0] <= bus_in;
            st        <= S_WD1;
          end
          S_WD1: begin
            data[7:4] <= bus_in;
            req_q     <= 1'b1;
            st        <= S_TAR0;
          end
          S_TAR0: st <= S_TAR1;
          S_TAR1: st <= S_SYNC;
          S_SYNC:
            if (is_rd) begin
              data <= rsp_rdata;
              st   <= S_RD0;
            end else st <= S_TAR2;
          S_RD0:  st <= S_RD1;
          S_RD1:  st <= S_TAR2;
          S_TAR2: st <= S_TAR3;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign drive = (st == S_TAR1) || (st == S_SYNC) || (st == S_RD0) ||
                 (st == S_RD1) || (st == S_TAR2);
  assign bus_oe = drive && frame_n;

  always_comb begin
    case (st)
      S_SYNC:  bus_out = 4'b0000;
      S_RD0:   bus_out = data[3:0];
      S_RD1:   bus_out = data[7:4];
      default: bus_out = 4'b1111;
    endcase
  end

  assign req_valid = req_q;
  assign req_write = !is_rd;
  assign req_addr  = addr[DEC_BITS-1:0];
  assign req_flash = addr[SEL_BIT];
  assign req_wdata = data;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !bus_oe); // R1
  AST_IDSEL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDSEL && frame_n && bus_in != id_strap) |=> (st == S_IDLE && !req_valid)); // R3
  AST_MSIZE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MSIZE && frame_n && bus_in != 4'b0000) |=> (st == S_IDLE && !req_valid)); // R6
  AST_RREQ_AFTER_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> $past(st) == S_MSIZE); // R7
  AST_WREQ_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> $past(st) == S_WD1); // R8
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid); // R8
  AST_ABORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && !frame_n) |=> (!bus_oe && !req_valid)); // R9
endmodule

// File: tb/fwh_target_tb.sv
module fwh_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] MY_ID = 4'h6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  bus_in = 4'hF;
  logic [3:0]  bus_out;
  logic        bus_oe;
  logic        req_valid, req_write, req_flash;
  logic [19:0] req_addr;
  logic [7:0]  req_wdata;
  logic [7:0]  rsp_rdata = 8'h00;

  int nchk = 0;
  int nerr = 0;
  int nreq = 0;
  logic        last_write, last_flash;
  logic [19:0] last_addr;
  logic [7:0]  last_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwh_target dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .id_strap(MY_ID),
    .req_valid(req_valid), .req_write(req_write), .req_flash(req_flash),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata)
  );

  function automatic logic [7:0] model(logic [19:0] a, logic f);
    return a[7:0] ^ (f ? 8'hA5 : 8'h3C);
  endfunction

  always @(posedge clk) begin
    if (req_valid) begin
      nreq       <= nreq + 1;
      last_write <= req_write;
      last_flash <= req_flash;
      last_addr  <= req_addr;
      last_wdata <= req_wdata;
      if (!req_write) rsp_rdata <= model(req_addr, req_flash);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [3:0] nib, logic fr);
    @(negedge clk);
    bus_in  = nib;
    frame_n = fr;
    @(posedge clk);
    #1;
  endtask

  task automatic hdr(logic [3:0] start, logic [3:0] id, logic [27:0] a, logic [3:0] sz);
    cyc(start, 1'b0);
    cyc(id, 1'b1);
    for (int i = 0; i < 7; i++) cyc(a[4*(6-i) +: 4], 1'b1);
    cyc(sz, 1'b1);
  endtask

  task automatic quiet(int n, string tag);
    int bad = 0;
    repeat (n) begin
      cyc(4'hF, 1'b1);
      if (bus_oe !== 1'b0) bad++;
    end
    chk(tag, bad, 0);
  endtask

  task automatic do_read(logic [27:0] a);
    int n0 = nreq;
    logic [7:0] exp = model(a[19:0], a[22]);
    hdr(4'hD, MY_ID, a, 4'h0);
    chk("R7 no drive in first turnaround", bus_oe, 0);
    chk("R7 read request strobe", req_valid, 1);
    cyc(4'hF, 1'b1);
    chk("R7 single read request", nreq, n0 + 1);
    chk("R7 read flagged as read", last_write, 0);
    chk("R4 low 20 address bits", last_addr, a[19:0]);
    chk("R5 space select from bit 22", last_flash, a[22]);
    chk("R7 turnaround drive", {bus_oe, bus_out}, 5'h1F);
    cyc(4'hF, 1'b1);
    chk("R7 sync nibble", {bus_oe, bus_out}, 5'h10);
    cyc(4'hF, 1'b1);
    chk("R7 low data nibble", {bus_oe, bus_out}, {1'b1, exp[3:0]});
    cyc(4'hF, 1'b1);
    chk("R7 high data nibble", {bus_oe, bus_out}, {1'b1, exp[7:4]});
    cyc(4'hF, 1'b1);
    chk("R7 closing turnaround", {bus_oe, bus_out}, 5'h1F);
    cyc(4'hF, 1'b1);
    chk("R7 bus released", bus_oe, 0);
    cyc(4'hF, 1'b1);
    chk("R1 idle after read", bus_oe, 0);
  endtask

  task automatic do_write(logic [27:0] a, logic [7:0] d);
    int n0 = nreq;
    hdr(4'hE, MY_ID, a, 4'h0);
    cyc(d[3:0], 1'b1);
    cyc(d[7:4], 1'b1);
    chk("R8 no request before last nibble", nreq, n0);
    chk("R8 write strobe", req_valid, 1);
    chk("R8 write flag", req_write, 1);
    chk("R8 write byte low first", req_wdata, d);
    chk("R4 write address", req_addr, a[19:0]);
    chk("R5 write space select", req_flash, a[22]);
    chk("R8 quiet first turnaround", bus_oe, 0);
    cyc(4'hF, 1'b1);
    chk("R8 turnaround drive", {bus_oe, bus_out}, 5'h1F);
    cyc(4'hF, 1'b1);
    chk("R8 sync nibble", {bus_oe, bus_out}, 5'h10);
    cyc(4'hF, 1'b1);
    chk("R8 closing turnaround", {bus_oe, bus_out}, 5'h1F);
    cyc(4'hF, 1'b1);
    chk("R8 bus released", bus_oe, 0);
    cyc(4'hF, 1'b1);
    chk("R8 exactly one request", nreq, n0 + 1);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset drive off", bus_oe, 0);
    chk("R1 reset no request", req_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    quiet(3, "R1 idle after reset");
  endtask

  task automatic test_reads();
    do_read(28'h0400123);
    do_read(28'h00ABC5E);
    do_read(28'hF7ABC5E);
  endtask

  task automatic test_writes();
    do_write(28'h04F00A1, 8'h5A);
    do_write(28'h3B12345, 8'hFF);
  endtask

  task automatic test_bad_start();
    int n0 = nreq;
    hdr(4'h5, MY_ID, 28'h0400000, 4'h0);
    quiet(8, "R2 bad start stays quiet");
    chk("R2 bad start no request", nreq, n0);
  endtask

  task automatic test_bad_id();
    int n0 = nreq;
    hdr(4'hD, MY_ID ^ 4'h1, 28'h0400010, 4'h0);
    quiet(8, "R3 foreign device select quiet");
    chk("R3 foreign device select no request", nreq, n0);
  endtask

  task automatic test_bad_size();
    int n0 = nreq;
    hdr(4'hD, MY_ID, 28'h0400020, 4'h1);
    quiet(8, "R6 bad size read quiet");
    hdr(4'hE, MY_ID, 28'h0400020, 4'h2);
    quiet(8, "R6 bad size write quiet");
    chk("R6 bad size no request", nreq, n0);
  endtask

  task automatic test_aborts();
    int n0;
    hdr(4'hD, MY_ID, 28'h0400033, 4'h0);
    cyc(4'hF, 1'b1);
    chk("R9 read drives before abort", bus_oe, 1);
    @(negedge clk);
    frame_n = 1'b0;
    #1;
    chk("R9 abort releases same clock", bus_oe, 0);
    @(posedge clk);
    #1;
    chk("R9 abort leaves bus free", bus_oe, 0);
    quiet(8, "R9 quiet after read abort");
    n0 = nreq;
    hdr(4'hE, MY_ID, 28'h0400044, 4'h0);
    cyc(4'h7, 1'b1);
    cyc(4'hF, 1'b0);
    quiet(6, "R9 quiet after write abort");
    chk("R9 half written byte no request", nreq, n0);
    n0 = nreq;
    hdr(4'hE, MY_ID, 28'h0400055, 4'h0);
    cyc(4'h3, 1'b1);
    cyc(4'hC, 1'b1);
    cyc(4'hF, 1'b0);
    quiet(6, "R9 quiet after late abort");
    chk("R9 late abort keeps request", nreq, n0 + 1);
    chk("R9 late abort request byte", last_wdata, 8'hC3);
    do_read(28'h0400066);
  endtask

  initial begin
    test_reset();
    test_reads();
    test_writes();
    test_bad_start();
    test_bad_id();
    test_bad_size();
    test_aborts();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule